// File: doc/BRIEF.md
# Eight-bit capture/compare timer with pulse-width output

This block is a small timer peripheral for a microcontroller. An 8-bit counter advances on a prescaled tick. The prescaler takes its rate from the CPU clock enable or from a slow oscillator tick, as a 2-bit field selects. Two input pins are synchronised and watched for an edge of a chosen polarity. On that edge the counter value is copied into a capture register. Two compare registers raise flags when the counter reaches them.

With pulse-width mode enabled, compare register 2 sets the period and compare register 1 sets the high time on the output pin. The counter reloads to zero after it matches compare register 2. In this mode the capture-1 flag marks the end of each period.

Software reaches the block through a synchronous register bus: address, read strobe, write strobe, write data and combinational read data. Status flags clear through a two-step sequence: a status read that sees the flag set, then a read or write of the data register tied to that flag. A status bit freezes the timer while the registers stay accessible.

Top module: `cc_timer8`

Register addresses: 0 control, 1 status, 2 capture 1, 3 capture 2, 4 compare 1, 5 compare 2, 6 counter (writes ignored), 7 reads 00h.
Control bits: bit 5 edge select 1, bit 4 pulse mode, bits 3:2 rate select, bit 1 edge select 2.
Status bits: bit 7 capture-1 flag, bit 6 compare-1 flag, bit 5 overflow flag, bit 4 capture-2 flag, bit 3 compare-2 flag, bit 2 freeze (read/write).

## Requirements
- R1: After reset, the control register, status register and counter read 00h, and `cmp_o` is low.
- R2: Rate select (control bits 3:2) gives one counter step per 4 (00), 2 (01) or 8 (10) cycles with `cpu_en_i` high, or per SLOW_DIV (default 8000) cycles with `osc_tick_i` high (11). With `cpu_en_i` low, the three CPU-based rates do not advance.
- R3: A counter step from FFh to 00h sets the overflow flag (status bit 5).
- R4: A flag clears only on a read or write of its data register (capture 1 for bit 7, compare 1 for bit 6, counter for bit 5, capture 2 for bit 4, compare 2 for bit 3), and only if the most recent status read saw that flag set. Without such a status read, the access leaves the flag set.
- R5: When a set event and a clearing access for the same flag fall in the same cycle, the flag stays set.
- R6: While the freeze bit (status bit 2, writable) is 1, the counter and prescaler hold their values, and all registers remain readable and writable.
- R7: The compare-1 flag (status bit 6) is set on the step that brings the counter to the value of compare register 1.
- R8: Capture pin 2 triggers on a falling edge when control bit 1 is 0 and on a rising edge when it is 1. Control bit 5 does the same for pin 1. A capture copies the counter into the capture register and sets status bit 4 (pin 2) or bit 7 (pin 1). An edge of the other polarity does nothing.
- R9: In pulse mode (control bit 4), the counter runs from 0 to compare 2 and then reloads to 0, so the period is compare2+1 steps. `cmp_o` is high from the reload until the counter reaches compare 1. Outside pulse mode, `cmp_o` is low.
- R10: In pulse mode, the capture-1 flag is set at each reload, and pin 1 edges neither capture nor set the flag.
- R11: Control bits 7, 6 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |
| cap1_i | input | 1 | Capture pin 1, asynchronous |
| cap2_i | input | 1 | Capture pin 2, asynchronous |
| cpu_en_i | input | 1 | CPU clock enable for rates 00 to 10 |
| osc_tick_i | input | 1 | Slow oscillator tick for rate 11 |
| cmp_o | output | 1 | Pulse-width output |

## Verification
The properties assume that `rd_i` and `wr_i` are never high in the same cycle, and that capture pins are low while reset is released. They also assume that a pin level is held long enough to pass the synchroniser before it changes again. The stimulus keeps to this: it issues one bus access per cycle, starts with both pins low, and holds each pin level for at least six cycles. The one exception is the collision case, where the clearing read is deliberately placed on the cycle the capture lands.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0, A_STAT = 3'd1, A_CAP1 = 3'd2, A_CAP2 = 3'd3,
    A_CMP1 = 3'd4, A_CMP2 = 3'd5, A_CNT  = 3'd6, A_NONE = 3'd7
  } reg_addr_e;

  localparam int FLAG_N = 5;
  // flag vector index == status bit - 3
  localparam int F_OCF2 = 0;
  localparam int F_ICF2 = 1;
  localparam int F_TOF  = 2;
  localparam int F_OCF1 = 3;
  localparam int F_ICF1 = 4;
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int SLOW_DIV = 8000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       cpu_en_i,
  input  logic       osc_tick_i,
  output logic       tick_o
);
  localparam int PW = $clog2(SLOW_DIV + 1);

  logic [PW-1:0] pre_q, lim_m1;
  logic          active;

  always_comb begin
    unique case (sel_i)
      2'd0:    lim_m1 = PW'(3);
      2'd1:    lim_m1 = PW'(1);
      2'd2:    lim_m1 = PW'(7);
      default: lim_m1 = PW'(SLOW_DIV - 1);
    endcase
  end

  assign active = run_i & ((sel_i == 2'd3) ? osc_tick_i : cpu_en_i);
  // >= so a rate change to a shorter limit recovers at once
  assign tick_o = active && (pre_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else if (active) pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/tmr8_capture.sv
module tmr8_capture #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pin_i,
  input  logic         rise_i,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  output logic         evt_o,
  output logic [W-1:0] cap_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q, pin_s;

  assign pin_s = sync_q[SYNC-1];
  assign evt_o = en_i & (rise_i ? (pin_s & ~prev_q) : (~pin_s & prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cap_o  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_i};
      prev_q <= pin_s;
      if (evt_o) cap_o <= cnt_i;
    end
  end

  assert_capture_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> cap_o == $past(cnt_i));
endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] acc_i,
  input  logic         stat_rd_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] arm_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        // set has priority over a same-cycle clear
        flag_o[i] <= set_i[i] | (flag_o[i] & ~(acc_i[i] & arm_q[i]));
        if (stat_rd_i)     arm_q[i] <= flag_o[i];
        else if (acc_i[i]) arm_q[i] <= 1'b0;
      end
    end

    assert_flag_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[i]) |-> $past(acc_i[i] && arm_q[i] && !set_i[i]));
  end
endmodule

// File: rtl/cc_timer8.sv
module cc_timer8 #(
  parameter int CNT_W       = 8,
  parameter int SLOW_DIV    = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             cap1_i,
  input  logic             cap2_i,
  input  logic             cpu_en_i,
  input  logic             osc_tick_i,
  output logic             cmp_o
);
  import tmr8_pkg::*;

  localparam int PAD = CNT_W - 6;

  reg_addr_e          addr;
  logic               edge1_q, edge2_q, pwm_en_q, off_q;
  logic [1:0]         sel_q;
  logic [CNT_W-1:0]   cmp1_q, cmp2_q, cnt_q, cnt_nxt, cap1, cap2;
  logic               tick, reload, cap1_evt, cap2_evt, acc, stat_rd;
  logic [FLAG_N-1:0]  set_v, acc_v, flags;

  assign addr    = reg_addr_e'(addr_i);
  assign acc     = rd_i | wr_i;
  assign stat_rd = rd_i && (addr == A_STAT);

  always_comb begin
    acc_v         = '0;
    acc_v[F_ICF1] = acc && (addr == A_CAP1);
    acc_v[F_OCF1] = acc && (addr == A_CMP1);
    acc_v[F_TOF]  = acc && (addr == A_CNT);
    acc_v[F_ICF2] = acc && (addr == A_CAP2);
    acc_v[F_OCF2] = acc && (addr == A_CMP2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge1_q <= 1'b0; edge2_q <= 1'b0; pwm_en_q <= 1'b0; sel_q <= '0;
      off_q   <= 1'b0; cmp1_q  <= '0;   cmp2_q   <= '0;
    end else if (wr_i) begin
      unique case (addr)
        A_CTRL: begin
          edge1_q  <= wdata_i[5];
          pwm_en_q <= wdata_i[4];
          sel_q    <= wdata_i[3:2];
          edge2_q  <= wdata_i[1];
        end
        A_STAT:  off_q  <= wdata_i[2];
        A_CMP1:  cmp1_q <= wdata_i;
        A_CMP2:  cmp2_q <= wdata_i;
        default: ;
      endcase
    end
  end

  tmr8_prescaler #(.SLOW_DIV(SLOW_DIV)) u_pre (
    .clk_i, .rst_ni, .run_i(!off_q), .sel_i(sel_q),
    .cpu_en_i, .osc_tick_i, .tick_o(tick)
  );

  assign reload  = pwm_en_q && (cnt_q == cmp2_q);
  assign cnt_nxt = reload ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_o <= 1'b0;
    end else begin
      if (tick) cnt_q <= cnt_nxt;
      if (!pwm_en_q)                   cmp_o <= 1'b0;
      else if (tick && cnt_nxt == cmp1_q) cmp_o <= 1'b0;
      else if (tick && reload)         cmp_o <= 1'b1;
    end
  end

  tmr8_capture #(.W(CNT_W), .SYNC(SYNC_STAGES)) u_cap1 (
    .clk_i, .rst_ni, .pin_i(cap1_i), .rise_i(edge1_q), .en_i(!pwm_en_q),
    .cnt_i(cnt_q), .evt_o(cap1_evt), .cap_o(cap1)
  );

  tmr8_capture #(.W(CNT_W), .SYNC(SYNC_STAGES)) u_cap2 (
    .clk_i, .rst_ni, .pin_i(cap2_i), .rise_i(edge2_q), .en_i(1'b1),
    .cnt_i(cnt_q), .evt_o(cap2_evt), .cap_o(cap2)
  );

  always_comb begin
    set_v         = '0;
    set_v[F_TOF]  = tick && (cnt_q == '1);
    set_v[F_OCF1] = tick && (cnt_nxt == cmp1_q);
    set_v[F_OCF2] = tick && (cnt_nxt == cmp2_q) && !pwm_en_q;
    set_v[F_ICF1] = pwm_en_q ? (tick && reload) : cap1_evt;
    set_v[F_ICF2] = cap2_evt;
  end

  tmr8_flags #(.N(FLAG_N)) u_flags (
    .clk_i, .rst_ni, .set_i(set_v), .acc_i(acc_v), .stat_rd_i(stat_rd), .flag_o(flags)
  );

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata_o = {{PAD{1'b0}}, edge1_q, pwm_en_q, sel_q, edge2_q, 1'b0};
      A_STAT:  rdata_o = {flags, off_q, {PAD{1'b0}}};
      A_CAP1:  rdata_o = cap1;
      A_CAP2:  rdata_o = cap2;
      A_CMP1:  rdata_o = cmp1_q;
      A_CMP2:  rdata_o = cmp2_q;
      A_CNT:   rdata_o = cnt_q;
      default: rdata_o = '0;
    endcase
  end

  assert_hold_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |=> $stable(cnt_q));

  assert_pwm_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_q && tick && cnt_q == cmp2_q) |=> (cnt_q == '0));

  assert_wrap_tof_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q == '1) |=> flags[F_TOF]);

  assert_no_cap1_in_pwm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_q && $stable(pwm_en_q)) |-> !cap1_evt);
endmodule

// File: tb/tb_cc_timer8.sv
module tb_cc_timer8;
  localparam int A_CTRL = 0, A_STAT = 1, A_CAP1 = 2, A_CAP2 = 3;
  localparam int A_CMP1 = 4, A_CMP2 = 5, A_CNT = 6;

  logic       clk = 0, rst_ni = 0, rd = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       cap1 = 0, cap2 = 0, cpu_en = 1, osc = 0, cmp;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  cc_timer8 dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .cap1_i(cap1), .cap2_i(cap2),
    .cpu_en_i(cpu_en), .osc_tick_i(osc), .cmp_o(cmp)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd_reg(int a, output logic [7:0] d);
    @(negedge clk); addr = 3'(a); rd = 1;
    #1 d = rdata;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic wr_reg(int a, int v);
    @(negedge clk); addr = 3'(a); wdata = 8'(v); wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic steps(int gap, output int delta);
    logic [7:0] c0, c1;
    rd_reg(A_CNT, c0);
    repeat (gap - 1) @(posedge clk);
    rd_reg(A_CNT, c1);
    delta = int'(8'(c1 - c0));
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 cmp_o", int'(cmp), 0);
    rd_reg(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd_reg(A_STAT, d); chk("R1 stat", d, 0);
    rd_reg(A_CNT, d);  chk("R1 cnt", d, 0);
  endtask

  task automatic t_prescale;
    int dl;
    int sel_tab[3] = '{1, 0, 2};
    int div_tab[3] = '{2, 4, 8};
    for (int i = 0; i < 3; i++) begin
      wr_reg(A_CTRL, sel_tab[i] << 2);
      repeat (20) @(posedge clk);
      steps(40, dl); chk("R2 cpu rate", dl, 40 / div_tab[i]);
    end
    wr_reg(A_CTRL, 8'h04);
    cpu_en = 0;
    steps(40, dl); chk("R2 cpu_en low stalls", dl, 0);
    cpu_en = 1;
    osc = 1;
    wr_reg(A_CTRL, 8'h0C);
    repeat (20) @(posedge clk);
    steps(16000, dl); chk("R2 slow rate", dl, 2);
    osc = 0;
    wr_reg(A_CTRL, 8'h00);
  endtask

  task automatic t_hold;
    logic [7:0] a, b, d;
    wr_reg(A_STAT, 8'h04);
    rd_reg(A_STAT, d); chk("R6 freeze bit", int'(d[2]), 1);
    rd_reg(A_CNT, a);
    repeat (50) @(posedge clk);
    rd_reg(A_CNT, b); chk("R6 counter held", b, a);
    wr_reg(A_CMP2, 8'h5A);
    rd_reg(A_CMP2, d); chk("R6 regs accessible", d, 8'h5A);
  endtask

  task automatic t_overflow;
    logic [7:0] d;
    wr_reg(A_CTRL, 8'h04);
    wr_reg(A_STAT, 8'h00);
    repeat (600) @(posedge clk);
    wr_reg(A_STAT, 8'h04);
    rd_reg(A_STAT, d); chk("R3 overflow flag", int'(d[5]), 1);
    rd_reg(A_CNT, d);
    rd_reg(A_STAT, d); chk("R4 cleared after sequence", int'(d[5]), 0);
    wr_reg(A_STAT, 8'h00);
    repeat (600) @(posedge clk);
    wr_reg(A_STAT, 8'h04);
    rd_reg(A_CNT, d);
    rd_reg(A_STAT, d); chk("R4 no clear without status read", int'(d[5]), 1);
    rd_reg(A_CNT, d);
  endtask

  task automatic t_compare;
    logic [7:0] v, d;
    rd_reg(A_STAT, d);
    rd_reg(A_CNT, v);
    wr_reg(A_CMP1, int'(8'(v + 8'd5)));
    rd_reg(A_STAT, d); chk("R4 compare flag cleared by write", int'(d[6]), 0);
    wr_reg(A_CTRL, 8'h08);
    wr_reg(A_STAT, 8'h00);
    repeat (9) @(posedge clk);
    wr_reg(A_STAT, 8'h04);
    rd_reg(A_STAT, d); chk("R7 not before match", int'(d[6]), 0);
    wr_reg(A_STAT, 8'h00);
    repeat (60) @(posedge clk);
    wr_reg(A_STAT, 8'h04);
    rd_reg(A_STAT, d); chk("R7 set at match", int'(d[6]), 1);
  endtask

  task automatic t_capture;
    logic [7:0] v, v2, d;
    rd_reg(A_CNT, v);
    wr_reg(A_CTRL, 8'h00);
    @(negedge clk) cap2 = 1;
    repeat (6) @(posedge clk);
    rd_reg(A_STAT, d); chk("R8 wrong edge ignored", int'(d[4]), 0);
    @(negedge clk) cap2 = 0;
    repeat (6) @(posedge clk);
    rd_reg(A_STAT, d); chk("R8 falling capture flag", int'(d[4]), 1);
    rd_reg(A_CAP2, d); chk("R8 capture 2 value", d, v);
    rd_reg(A_STAT, d); chk("R4 capture flag cleared", int'(d[4]), 0);
    wr_reg(A_CTRL, 8'h20);
    @(negedge clk) cap1 = 1;
    repeat (6) @(posedge clk);
    rd_reg(A_STAT, d); chk("R8 pin1 rising flag", int'(d[7]), 1);
    rd_reg(A_CAP1, d); chk("R8 capture 1 value", d, v);
    wr_reg(A_STAT, 8'h00);
    repeat (30) @(posedge clk);
    wr_reg(A_STAT, 8'h04);
    rd_reg(A_CNT, v2);
    wr_reg(A_CTRL, 8'h02);
    @(negedge clk) cap2 = 1;
    repeat (6) @(posedge clk);
    rd_reg(A_CAP2, d); chk("R8 rising capture 2 value", d, v2);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    wr_reg(A_CTRL, 8'h00);
    rd_reg(A_STAT, d); chk("R5 flag set before", int'(d[4]), 1);
    @(negedge clk) cap2 = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 3'(A_CAP2); rd = 1;
    @(posedge clk); #1 rd = 0;
    rd_reg(A_STAT, d); chk("R5 set wins over clear", int'(d[4]), 1);
    rd_reg(A_CAP2, d);
    rd_reg(A_STAT, d); chk("R4 later clear", int'(d[4]), 0);
  endtask

  task automatic t_pwm;
    logic [7:0] d, p, mx;
    int hi = 0;
    wr_reg(A_CMP1, 3);
    wr_reg(A_CMP2, 9);
    wr_reg(A_CTRL, 8'h14);
    wr_reg(A_STAT, 8'h00);
    repeat (600) @(posedge clk);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1 if (cmp) hi++;
    end
    chk("R9 high cycles per 10 periods", hi, 60);
    rd_reg(A_STAT, d); chk("R10 period flag", int'(d[7]), 1);
    mx = 0;
    for (int i = 0; i < 40; i++) begin
      rd_reg(A_CNT, d);
      if (d > mx) mx = d;
    end
    chk("R9 counter peak", mx, 9);
    wr_reg(A_STAT, 8'h04);
    rd_reg(A_STAT, d);
    rd_reg(A_CAP1, p);
    rd_reg(A_STAT, d); chk("R10 flag cleared", int'(d[7]), 0);
    @(negedge clk) cap1 = 0;
    repeat (6) @(posedge clk);
    rd_reg(A_STAT, d); chk("R10 pin1 ignored flag", int'(d[7]), 0);
    rd_reg(A_CAP1, d); chk("R10 pin1 ignored value", d, p);
    wr_reg(A_CTRL, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R9 output low outside mode", int'(cmp), 0);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    wr_reg(A_CTRL, 8'hFF);
    rd_reg(A_CTRL, d); chk("R11 reserved bits", d, 8'h3E);
    wr_reg(A_CTRL, 8'h00);
  endtask

  function automatic void summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_ni = 1;
    t_reset();
    t_prescale();
    t_hold();
    t_overflow();
    t_compare();
    t_capture();
    t_collision();
    t_pwm();
    t_reserved();
    done = 1;
    summary();
    $finish;
  end
endmodule